// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a 32-bit host write port and a register file whose control registers are 128 bits wide. The host can only deliver one dword per write, so the block gathers the four dwords of a wide register in a collector and sends them on as a single 128-bit commit once the last one arrives. A region of 64-bit on-chip memory words uses the same collector and commits when both halves are present. Writes to ordinary 32-bit locations go straight through and leave the collector alone.

Per-queue registers are replicated in pages of a fixed power-of-two stride. In each page, two descriptor-pointer doorbells are 128 bits wide but take a fast path. A write to a doorbell's top dword always commits at once. If the collector does not already hold all three lower dwords of that same doorbell, those lower 96 bits are filled with zero. A write to a lower doorbell dword is dropped when the collector is busy with some other register, so it cannot corrupt that collection. An optional mode lets a write to the timer-command location in page 0 empty the collector.

Each accepted write yields at most one commit: a single-cycle strobe with a kind code, an aligned address and 128 bits of data, one cycle after the write.

Top module: `wide_write_collector`

## Requirements
- R1: A write into the wide-register region (byte addresses below 0x1000; dword index is address bits [3:2]) commits only once all four dwords of one 16-byte-aligned register are held, in any arrival order. It commits with kind 1, the 16-aligned address, and dword n placed in data bits [32n+31:32n].
- R2: A wide or memory write to a register other than the one being collected throws away the pending partial data and starts a new collection holding only the new dword.
- R3: A write into the memory region (0x1000 to 0x1FFF; half index is address bit 2) commits once both halves of an 8-aligned word are held. It commits with kind 2, the 8-aligned address, the word in data bits [63:0] and zeros in bits [127:64].
- R4: A write to a doorbell's top dword (offset +0xC) always commits one cycle later with kind 3 and the 16-aligned address. Data bits [127:96] are the written value. Bits [95:0] are the collected dwords if the collector holds all three lower dwords of that doorbell, and zero otherwise. The collector is left empty.
- R5: A write to a lower doorbell dword while the collector holds a different register is discarded, and the collector is left unchanged.
- R6: A write anywhere outside the wide, memory and doorbell locations commits next cycle with kind 0, the dword-aligned address and the value zero-extended to 128 bits, and leaves the collector unchanged.
- R7: The paged area starts at 0x8000 and holds 4 pages of stride 0x2000. In every page, offsets 0x830 and 0xA10 are doorbells, and every other offset is a plain location.
- R8: With the option enabled (default), a write to offset 0x420 of page 0 commits as plain and also empties the collector. The same offset in any other page does not empty it.
- R9: A commit is a strobe lasting one cycle, appears only in the cycle after a write, and leaves the collector empty once a register is complete.
- R10: Synchronous active-high reset removes any commit and empties the collector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | AW (20) | Byte address of the write |
| wr_data | input | 32 | Write data |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_kind | output | 2 | 0 plain, 1 wide, 2 memory word, 3 doorbell |
| commit_addr | output | AW (20) | Aligned address of the committed location |
| commit_data | output | 128 | Committed data, zero-extended for narrow kinds |

## Verification
The main function is driven with four dwords in scrambled order, with two collections interleaved so one displaces the other, and with plain writes inserted into an open collection. Together these separate correct merging from loss or corruption of pending data. Doorbell tops are sent with a full lower set, with a partial set, with nothing collected, and while another register is pending; the last pattern tells fast-path zero-fill apart from wrongly reusing another register's data. Timer writes to page 0 and page 1, and a reset in the middle of a collection, show whether the collector is emptied exactly when it should be.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
   localparam int unsigned DWORD_W = 32;
   localparam int unsigned WIDE_W  = 128;

   typedef enum logic [1:0] {
      KIND_PLAIN    = 2'd0,
      KIND_WIDE     = 2'd1,
      KIND_SRAM     = 2'd2,
      KIND_DOORBELL = 2'd3
   } commit_kind_e;

   typedef enum logic [1:0] {
      RGN_PLAIN    = 2'd0,
      RGN_WIDE     = 2'd1,
      RGN_SRAM     = 2'd2,
      RGN_DOORBELL = 2'd3
   } region_e;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
   import wwc_pkg::*;
#(
   parameter int unsigned AW                = 20,
   parameter int unsigned CSR_BYTES         = 32'h1000,
   parameter int unsigned SRAM_BASE         = 32'h1000,
   parameter int unsigned SRAM_BYTES        = 32'h1000,
   parameter int unsigned PAGE_BASE         = 32'h8000,
   parameter int unsigned PAGE_SHIFT        = 13,
   parameter int unsigned NUM_PAGES         = 4,
   parameter int unsigned DB_LO_OFS         = 32'h830,
   parameter int unsigned DB_HI_OFS         = 32'hA10,
   parameter int unsigned TIMER_OFS         = 32'h420,
   parameter bit          TIMER_INVALIDATES = 1'b1
) (
   input  logic [AW-1:0] addr,
   output region_e       region,
   output logic          inval
);
   localparam int unsigned STRIDE   = 32'd1 << PAGE_SHIFT;
   localparam int unsigned PAGE_END = PAGE_BASE + NUM_PAGES * STRIDE;
   localparam int unsigned NUM_DB   = 2;
   localparam int unsigned DB_OFS [NUM_DB] = '{DB_LO_OFS, DB_HI_OFS};

   if (AW > 31) begin : g_bad_aw
      $error("wwc_decode: AW must not exceed 31");
   end
   if (PAGE_SHIFT < 12 || PAGE_SHIFT >= AW) begin : g_bad_stride
      $error("wwc_decode: page stride out of range");
   end
   if (PAGE_END > (32'd1 << AW)) begin : g_bad_pages
      $error("wwc_decode: paged area exceeds address space");
   end
   if ((PAGE_BASE % STRIDE) != 0) begin : g_bad_base
      $error("wwc_decode: page base must be stride aligned");
   end

   logic [31:0] a32, off, page;
   logic        in_csr, in_sram, in_pages, timer_p0;
   logic [NUM_DB-1:0] db_match;

   assign a32  = 32'(addr);
   assign off  = a32 & (STRIDE - 32'd1);
   assign page = (a32 - PAGE_BASE) >> PAGE_SHIFT;

   for (genvar g = 0; g < NUM_DB; g++) begin : g_db
      assign db_match[g] = (off >> 4) == (DB_OFS[g] >> 4);
   end

   assign in_csr   = a32 < CSR_BYTES;
   assign in_sram  = (a32 >= SRAM_BASE) && (a32 < SRAM_BASE + SRAM_BYTES);
   assign in_pages = (a32 >= PAGE_BASE) && (a32 < PAGE_END);
   assign timer_p0 = in_pages && (page == 32'd0) && ((off >> 2) == (TIMER_OFS >> 2));

   always_comb begin
      if (in_csr)                      region = RGN_WIDE;
      else if (in_sram)                region = RGN_SRAM;
      else if (in_pages && |db_match)  region = RGN_DOORBELL;
      else                             region = RGN_PLAIN;
   end

   if (TIMER_INVALIDATES) begin : g_timer_inval
      assign inval = timer_p0;
   end else begin : g_timer_plain
      assign inval = 1'b0;
   end
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
   import wwc_pkg::*;
#(
   parameter int unsigned AW = 20
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_valid,
   input  region_e             region,
   input  logic                inval,
   input  logic [AW-1:0]       addr,
   input  logic [DWORD_W-1:0]  wdata,
   output logic                fire,
   output commit_kind_e        kind,
   output logic [AW-1:0]       caddr,
   output logic [WIDE_W-1:0]   cdata
);
   localparam int unsigned LANES = WIDE_W / DWORD_W;

   logic [LANES-1:0]  mask_q, mask_n, lane_oh, merged_mask;
   logic [AW-1:0]     addr_q, addr_n, tgt;
   logic              sram_q, sram_n, is_sram, hit, full;
   logic [WIDE_W-1:0] data_q, data_n, merged_data;
   logic [1:0]        lane;

   always_comb begin
      is_sram = (region == RGN_SRAM);
      tgt     = addr & (is_sram ? ~AW'(7) : ~AW'(15));
      lane    = is_sram ? {1'b0, addr[2]} : addr[3:2];
      lane_oh = LANES'(1) << lane;
      hit     = (mask_q != '0) && (addr_q == tgt) && (sram_q == is_sram);

      merged_mask = (hit ? mask_q : '0) | lane_oh;
      merged_data = hit ? data_q : '0;
      for (int i = 0; i < LANES; i++) begin
         if (lane_oh[i]) merged_data[DWORD_W*i +: DWORD_W] = wdata;
      end
      full = is_sram ? (&merged_mask[1:0]) : (&merged_mask);

      fire   = 1'b0;
      kind   = KIND_PLAIN;
      caddr  = tgt;
      cdata  = merged_data;
      mask_n = mask_q;
      addr_n = addr_q;
      sram_n = sram_q;
      data_n = data_q;

      if (wr_valid) begin
         unique case (region)
            RGN_PLAIN: begin
               fire  = 1'b1;
               caddr = addr & ~AW'(3);
               cdata = {{(WIDE_W-DWORD_W){1'b0}}, wdata};
               if (inval) mask_n = '0;
            end
            RGN_WIDE, RGN_SRAM: begin
               if (full) begin
                  fire   = 1'b1;
                  kind   = is_sram ? KIND_SRAM : KIND_WIDE;
                  cdata  = is_sram ? {64'b0, merged_data[63:0]} : merged_data;
                  mask_n = '0;
               end else begin
                  mask_n = merged_mask;
                  addr_n = tgt;
                  sram_n = is_sram;
                  data_n = merged_data;
               end
            end
            RGN_DOORBELL: begin
               if (lane == 2'd3) begin
                  fire   = 1'b1;
                  kind   = KIND_DOORBELL;
                  cdata  = {wdata, (hit && (&mask_q[2:0])) ? data_q[95:0] : 96'b0};
                  mask_n = '0;
               end else if (mask_q == '0 || hit) begin
                  mask_n = merged_mask;
                  addr_n = tgt;
                  sram_n = 1'b0;
                  data_n = merged_data;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= '0;
         addr_q <= '0;
         sram_q <= 1'b0;
         data_q <= '0;
      end else begin
         mask_q <= mask_n;
         addr_q <= addr_n;
         sram_q <= sram_n;
         data_q <= data_n;
      end
   end

   AST_PLAIN_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && region == RGN_PLAIN && !inval) |=> ($stable(mask_q) && $stable(data_q))); // R6
   AST_DISCARD_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && region == RGN_DOORBELL && addr[3:2] != 2'd3 && mask_q != '0 && !hit)
      |=> ($stable(mask_q) && $stable(addr_q) && $stable(data_q))); // R5
   AST_EMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
      (fire && region != RGN_PLAIN) |=> (mask_q == '0)); // R9
   AST_TIMER_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && inval) |=> (mask_q == '0)); // R8
endmodule

// File: rtl/wwc_commit_reg.sv
module wwc_commit_reg
   import wwc_pkg::*;
#(
   parameter int unsigned AW = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  commit_kind_e      kind,
   input  logic [AW-1:0]     caddr,
   input  logic [WIDE_W-1:0] cdata,
   output logic              commit_valid,
   output logic [1:0]        commit_kind,
   output logic [AW-1:0]     commit_addr,
   output logic [WIDE_W-1:0] commit_data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         commit_valid <= 1'b0;
         commit_kind  <= 2'd0;
         commit_addr  <= '0;
         commit_data  <= '0;
      end else begin
         commit_valid <= fire;
         if (fire) begin
            commit_kind <= kind;
            commit_addr <= caddr;
            commit_data <= cdata;
         end
      end
   end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
   import wwc_pkg::*;
#(
   parameter int unsigned AW                = 20,
   parameter int unsigned CSR_BYTES         = 32'h1000,
   parameter int unsigned SRAM_BASE         = 32'h1000,
   parameter int unsigned SRAM_BYTES        = 32'h1000,
   parameter int unsigned PAGE_BASE         = 32'h8000,
   parameter int unsigned PAGE_SHIFT        = 13,
   parameter int unsigned NUM_PAGES         = 4,
   parameter int unsigned DB_LO_OFS         = 32'h830,
   parameter int unsigned DB_HI_OFS         = 32'hA10,
   parameter int unsigned TIMER_OFS         = 32'h420,
   parameter bit          TIMER_INVALIDATES = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_valid,
   input  logic [AW-1:0] wr_addr,
   input  logic [31:0]   wr_data,
   output logic          commit_valid,
   output logic [1:0]    commit_kind,
   output logic [AW-1:0] commit_addr,
   output logic [127:0]  commit_data
);
   region_e           rgn;
   logic              inval, fire;
   commit_kind_e      kind;
   logic [AW-1:0]     caddr;
   logic [WIDE_W-1:0] cdata;

   wwc_decode #(
      .AW(AW), .CSR_BYTES(CSR_BYTES), .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES),
      .PAGE_BASE(PAGE_BASE), .PAGE_SHIFT(PAGE_SHIFT), .NUM_PAGES(NUM_PAGES),
      .DB_LO_OFS(DB_LO_OFS), .DB_HI_OFS(DB_HI_OFS), .TIMER_OFS(TIMER_OFS),
      .TIMER_INVALIDATES(TIMER_INVALIDATES)
   ) u_decode (
      .addr(wr_addr), .region(rgn), .inval(inval)
   );

   wwc_collector #(.AW(AW)) u_collect (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .region(rgn), .inval(inval),
      .addr(wr_addr), .wdata(wr_data), .fire(fire), .kind(kind),
      .caddr(caddr), .cdata(cdata)
   );

   wwc_commit_reg #(.AW(AW)) u_commit (
      .clk(clk), .rst(rst), .fire(fire), .kind(kind), .caddr(caddr), .cdata(cdata),
      .commit_valid(commit_valid), .commit_kind(commit_kind),
      .commit_addr(commit_addr), .commit_data(commit_data)
   );

   AST_COMMIT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
      commit_valid |-> $past(wr_valid)); // R9
   AST_DOORBELL_TOP_COMMITS: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && rgn == RGN_DOORBELL && wr_addr[3:2] == 2'd3)
      |=> (commit_valid && commit_kind == 2'd3)); // R4
   AST_SRAM_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (commit_valid && commit_kind == 2'd2) |-> (commit_data[127:64] == 64'b0)); // R3
   AST_PLAIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (commit_valid && commit_kind == 2'd0) |-> (commit_data[127:32] == 96'b0)); // R6
endmodule

// File: tb/tb_wide_write_collector.sv
`timescale 1ns/1ps
module tb_wide_write_collector;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_valid = 1'b0;
   logic [19:0]  wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic         commit_valid;
   logic [1:0]   commit_kind;
   logic [19:0]  commit_addr;
   logic [127:0] commit_data;

   always #4 clk = ~clk;

   wide_write_collector dut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit_valid(commit_valid), .commit_kind(commit_kind),
      .commit_addr(commit_addr), .commit_data(commit_data)
   );

   typedef struct {
      logic [1:0]   kind;
      logic [19:0]  addr;
      logic [127:0] data;
      string        req;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0, fails = 0, unexp = 0, snap = 0;
   bit done = 1'b0;

   function automatic logic [19:0] pg(input int page, input int off);
      return 20'(32'h8000 + page * 32'h2000 + off);
   endfunction

   task automatic expect_commit(input logic [1:0] k, input logic [19:0] a,
                                input logic [127:0] d, input string r);
      exp_t e;
      e.kind = k; e.addr = a; e.data = d; e.req = r;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [19:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic none_begin();
      snap = unexp;
   endtask

   task automatic none_end(input string r);
      repeat (2) @(negedge clk);
      checks++;
      if (unexp != snap) begin
         fails++;
         $display("FAIL %s: unexpected commits %0d, expected 0", r, unexp - snap);
      end
   endtask

   // monitor: compares every commit with the scoreboard head
   always @(negedge clk) begin
      if (!rst && commit_valid) begin
         if (exp_q.size() == 0) begin
            unexp++;
            $display("FAIL unexpected commit kind=%0d addr=%h data=%h, expected none",
                     commit_kind, commit_addr, commit_data);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (commit_kind !== e.kind || commit_addr !== e.addr || commit_data !== e.data) begin
               fails++;
               $display("FAIL %s: got kind=%0d addr=%h data=%h, expected kind=%0d addr=%h data=%h",
                        e.req, commit_kind, commit_addr, commit_data, e.kind, e.addr, e.data);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (commit_valid !== 1'b0) begin
         fails++;
         $display("FAIL R10: commit_valid=%b after reset, expected 0", commit_valid);
      end

      // R1: scrambled order 3,1,0,2
      wr(20'h040 + 12, 32'hA3A3A3A3);
      wr(20'h040 + 4,  32'hA1A1A1A1);
      wr(20'h040 + 0,  32'hA0A0A0A0);
      expect_commit(2'd1, 20'h040, {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1, 32'hA0A0A0A0}, "R1");
      wr(20'h040 + 8,  32'hA2A2A2A2);

      // R9: collector empty after commit, same register needs four new dwords
      none_begin();
      wr(20'h040 + 0, 32'h11110000);
      wr(20'h040 + 4, 32'h11110001);
      wr(20'h040 + 8, 32'h11110002);
      none_end("R9");
      expect_commit(2'd1, 20'h040, {32'h11110003, 32'h11110002, 32'h11110001, 32'h11110000}, "R9");
      wr(20'h040 + 12, 32'h11110003);

      // R2: interleaved collection replaces pending data
      wr(20'h100 + 0, 32'hB0B0B0B0);
      wr(20'h100 + 4, 32'hB1B1B1B1);
      wr(20'h200 + 0, 32'hC0C0C0C0);
      wr(20'h200 + 4, 32'hC1C1C1C1);
      wr(20'h200 + 8, 32'hC2C2C2C2);
      expect_commit(2'd1, 20'h200, {32'hC3C3C3C3, 32'hC2C2C2C2, 32'hC1C1C1C1, 32'hC0C0C0C0}, "R2");
      wr(20'h200 + 12, 32'hC3C3C3C3);
      none_begin();
      wr(20'h100 + 8,  32'hB2B2B2B2);
      wr(20'h100 + 12, 32'hB3B3B3B3);
      none_end("R2");

      // R3: memory words, high half first then low
      wr(20'h100C, 32'h5EED0001);
      expect_commit(2'd2, 20'h1008, {64'b0, 32'h5EED0001, 32'h5EED0000}, "R3");
      wr(20'h1008, 32'h5EED0000);
      wr(20'h1FF0, 32'h77770000);
      expect_commit(2'd2, 20'h1FF0, {64'b0, 32'h77770001, 32'h77770000}, "R3");
      wr(20'h1FF4, 32'h77770001);

      // R6: plain writes inside an open collection
      wr(20'h300 + 0, 32'hD0D0D0D0);
      wr(20'h300 + 4, 32'hD1D1D1D1);
      expect_commit(2'd0, 20'h3004, {96'b0, 32'h0BAD0001}, "R6");
      wr(20'h3006, 32'h0BAD0001);
      expect_commit(2'd0, pg(0, 32'h400), {96'b0, 32'h0BAD0002}, "R7");
      wr(pg(0, 32'h400), 32'h0BAD0002);
      expect_commit(2'd0, 20'h18000, {96'b0, 32'h0BAD0003}, "R7");
      wr(20'h18000, 32'h0BAD0003);
      wr(20'h300 + 8, 32'hD2D2D2D2);
      expect_commit(2'd1, 20'h300, {32'hD3D3D3D3, 32'hD2D2D2D2, 32'hD1D1D1D1, 32'hD0D0D0D0}, "R6");
      wr(20'h300 + 12, 32'hD3D3D3D3);

      // R4: full doorbell in page 2 at offset 0xA10
      wr(pg(2, 32'hA10) + 0, 32'hE0E0E0E0);
      wr(pg(2, 32'hA10) + 4, 32'hE1E1E1E1);
      wr(pg(2, 32'hA10) + 8, 32'hE2E2E2E2);
      expect_commit(2'd3, pg(2, 32'hA10), {32'hE3E3E3E3, 32'hE2E2E2E2, 32'hE1E1E1E1, 32'hE0E0E0E0}, "R4");
      wr(pg(2, 32'hA10) + 12, 32'hE3E3E3E3);

      // R4: partial doorbell in page 1 at offset 0x830 -> zero fill
      wr(pg(1, 32'h830) + 0, 32'hF0F0F0F0);
      wr(pg(1, 32'h830) + 4, 32'hF1F1F1F1);
      expect_commit(2'd3, pg(1, 32'h830), {32'hF3F3F3F3, 96'b0}, "R4");
      wr(pg(1, 32'h830) + 12, 32'hF3F3F3F3);
      expect_commit(2'd3, pg(3, 32'hA10), {32'h12345678, 96'b0}, "R7");
      wr(pg(3, 32'hA10) + 12, 32'h12345678);

      // R5: conflicting lower doorbell dword dropped
      wr(20'h400 + 0, 32'h60606060);
      wr(20'h400 + 4, 32'h61616161);
      none_begin();
      wr(pg(0, 32'h830) + 0, 32'hDEADDEAD);
      none_end("R5");
      wr(20'h400 + 8, 32'h62626262);
      expect_commit(2'd1, 20'h400, {32'h63636363, 32'h62626262, 32'h61616161, 32'h60606060}, "R5");
      wr(20'h400 + 12, 32'h63636363);
      expect_commit(2'd3, pg(0, 32'h830), {32'h9ABCDEF0, 96'b0}, "R5");
      wr(pg(0, 32'h830) + 12, 32'h9ABCDEF0);

      // R4: top dword while another register is pending
      wr(20'h500 + 0, 32'h70707070);
      expect_commit(2'd3, pg(0, 32'h830), {32'h0F0F0F0F, 96'b0}, "R4");
      wr(pg(0, 32'h830) + 12, 32'h0F0F0F0F);
      none_begin();
      wr(20'h500 + 4,  32'h71717171);
      wr(20'h500 + 8,  32'h72727272);
      wr(20'h500 + 12, 32'h73737373);
      none_end("R4");

      // R8: timer in page 0 empties collector, page 1 does not
      wr(20'h600 + 0, 32'h80808080);
      wr(20'h600 + 4, 32'h81818181);
      wr(20'h600 + 8, 32'h82828282);
      expect_commit(2'd0, pg(0, 32'h420), {96'b0, 32'h00000055}, "R8");
      wr(pg(0, 32'h420), 32'h00000055);
      none_begin();
      wr(20'h600 + 12, 32'h83838383);
      none_end("R8");
      wr(20'h700 + 0, 32'h90909090);
      wr(20'h700 + 4, 32'h91919191);
      wr(20'h700 + 8, 32'h92929292);
      expect_commit(2'd0, pg(1, 32'h420), {96'b0, 32'h00000066}, "R8");
      wr(pg(1, 32'h420), 32'h00000066);
      expect_commit(2'd1, 20'h700, {32'h93939393, 32'h92929292, 32'h91919191, 32'h90909090}, "R8");
      wr(20'h700 + 12, 32'h93939393);

      // R10: reset in the middle of a collection
      wr(20'h800 + 0, 32'hAA000000);
      wr(20'h800 + 4, 32'hAA000001);
      wr(20'h800 + 8, 32'hAA000002);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      none_begin();
      wr(20'h800 + 12, 32'hAA000003);
      none_end("R10");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R9: %0d expected commits never arrived, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule